// File: doc/BRIEF.md
# Vector Pairwise Transpose Unit

This block is a SIMD permute stage for a vector datapath. It accepts two 128-bit source vectors, A and B, and an element-size code. For every pair of adjacent element lanes it performs a 2x2 transpose. It returns two result vectors at once: the *even* result is built from the even-numbered source lanes, and the *odd* result from the odd-numbered ones. Taken together, the two results hold the transposed 2x2 tile of each lane pair. Shift-and-merge sequences are therefore not needed to emulate this step.

Lane i of a vector occupies bits `[i*W +: W]`, where W is the element width. Software or an external sequencer builds larger transposes by issuing several operations with different element widths. A 4x4 tile of 16-bit rows takes a 32-bit round followed by a 16-bit round. An 8x8 tile takes rounds at 16, 32 and 64 bits.

The result is registered once. Both result vectors and the output valid appear one clock after an accepted input. The registered outputs hold their value between operations.

Top module: `vtrn_pair_unit`

## Requirements
- R1: With size code 0 (16-bit, 8 lanes), for every pair k the even result has A lane 2k in lane 2k and B lane 2k in lane 2k+1, and the odd result has A lane 2k+1 in lane 2k and B lane 2k+1 in lane 2k+1.
- R2: With size code 1 (32-bit, 4 lanes), the same even/odd lane mapping as R1 applies on 32-bit lanes.
- R3: With size code 2 (64-bit, 2 lanes), the even result is {B lane 0, A lane 0} and the odd result is {B lane 1, A lane 1}, where lane 0 is the low half.
- R4: With size code 3 (unsupported), the even result equals A and the odd result equals B, unchanged.
- R5: Results and `out_valid` change on the clock edge after the one that samples `in_valid` high. `out_valid` is low after every edge at which `in_valid` was low.
- R6: While `in_valid` is low, both result vectors keep their previous value.
- R7: While reset is asserted, `out_valid` is 0 and both result vectors are all zeros.
- R8: A 32-bit round on row pairs (0,2) and (1,3), followed by a 16-bit round on the intermediates, transposes each 4x4 tile of 16-bit elements held in four row vectors.
- R9: Three rounds at 16, 32 and 64 bits transpose an 8x8 tile of 16-bit elements held in eight row vectors.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request; sources are sampled when high |
| src_a | input | 128 | Source vector A |
| src_b | input | 128 | Source vector B |
| elem_sz | input | 2 | Element size code: 0=16, 1=32, 2=64 bits, 3=pass through |
| out_valid | output | 1 | Results updated at this edge |
| res_even | output | 128 | Even-lane transpose result |
| res_odd | output | 128 | Odd-lane transpose result |

## Verification
The lane mapping is first tried with random sources at every size code. Random data separates a swapped A/B selection or a wrong lane index, which constant data would hide. Lane-numbered rows are then chained through full 4x4 and 8x8 transposes. These expose any mixing of the even and odd results, or a wrong width per round, that a single operation could still pass. Back-to-back requests and idle gaps are interleaved, which separates the one-cycle latency from the hold behaviour. The unsupported code 3 separates pass-through from a silently chosen width.

// File: rtl/vtrn_pkg.sv
package vtrn_pkg;
  localparam int VEC_W     = 128;
  localparam int BASE_W    = 16;
  localparam int NUM_SIZES = 3;
  localparam int SZ_W      = 2;

  typedef enum logic [SZ_W-1:0] {
    ESZ_16  = 2'd0,
    ESZ_32  = 2'd1,
    ESZ_64  = 2'd2,
    ESZ_RSV = 2'd3
  } esz_e;
endpackage

// File: rtl/vtrn_rst_sync.sv
module vtrn_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/vtrn_lane_pair.sv
module vtrn_lane_pair #(
  parameter int VEC_W = vtrn_pkg::VEC_W,
  parameter int EW    = vtrn_pkg::BASE_W
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic [VEC_W-1:0] even_o,
  output logic [VEC_W-1:0] odd_o
);
  localparam int LANES = VEC_W / EW;
  localparam int PAIRS = LANES / 2;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    localparam int LO = (2*k)   * EW;
    localparam int HI = (2*k+1) * EW;
    assign even_o[LO +: EW] = a_i[LO +: EW];
    assign even_o[HI +: EW] = b_i[LO +: EW];
    assign odd_o[LO +: EW]  = a_i[HI +: EW];
    assign odd_o[HI +: EW]  = b_i[HI +: EW];
  end
endmodule

// File: rtl/vtrn_size_mux.sv
module vtrn_size_mux #(
  parameter int VEC_W     = vtrn_pkg::VEC_W,
  parameter int NUM_SIZES = vtrn_pkg::NUM_SIZES,
  parameter int SZ_W      = vtrn_pkg::SZ_W
) (
  input  logic [SZ_W-1:0]                 sz_i,
  input  logic [VEC_W-1:0]                a_i,
  input  logic [VEC_W-1:0]                b_i,
  input  logic [NUM_SIZES-1:0][VEC_W-1:0] cand_even_i,
  input  logic [NUM_SIZES-1:0][VEC_W-1:0] cand_odd_i,
  output logic [VEC_W-1:0]                even_o,
  output logic [VEC_W-1:0]                odd_o
);
  always_comb begin
    even_o = a_i;
    odd_o  = b_i;
    for (int g = 0; g < NUM_SIZES; g++) begin
      if (sz_i == SZ_W'(g)) begin
        even_o = cand_even_i[g];
        odd_o  = cand_odd_i[g];
      end
    end
  end
endmodule

// File: rtl/vtrn_pair_unit.sv
module vtrn_pair_unit
  import vtrn_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int BW = BASE_W,
  parameter int NS = NUM_SIZES,
  parameter int SW = SZ_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  input  logic [SW-1:0] elem_sz,
  output logic          out_valid,
  output logic [VW-1:0] res_even,
  output logic [VW-1:0] res_odd
);
  logic                 rst_sync_n;
  logic [NS-1:0][VW-1:0] cand_even, cand_odd;
  logic [VW-1:0]        sel_even, sel_odd;
  logic                 vld_d, vld_q;
  logic [VW-1:0]        even_d, even_q, odd_d, odd_q;

  vtrn_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NS; g++) begin : g_width
    vtrn_lane_pair #(.VEC_W(VW), .EW(BW << g)) u_lp (
      .a_i    (src_a),
      .b_i    (src_b),
      .even_o (cand_even[g]),
      .odd_o  (cand_odd[g])
    );
  end

  vtrn_size_mux #(.VEC_W(VW), .NUM_SIZES(NS), .SZ_W(SW)) u_mux (
    .sz_i        (elem_sz),
    .a_i         (src_a),
    .b_i         (src_b),
    .cand_even_i (cand_even),
    .cand_odd_i  (cand_odd),
    .even_o      (sel_even),
    .odd_o       (sel_odd)
  );

  always_comb begin
    vld_d  = in_valid;
    even_d = even_q;
    odd_d  = odd_q;
    if (in_valid) begin
      even_d = sel_even;
      odd_d  = sel_odd;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      even_q <= '0;
      odd_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      even_q <= even_d;
      odd_q  <= odd_d;
    end
  end

  assign out_valid = vld_q;
  assign res_even  = even_q;
  assign res_odd   = odd_q;
endmodule

// File: rtl/vtrn_pair_unit_chk.sv
module vtrn_pair_unit_chk #(
  parameter int VW = 128,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [VW-1:0] src_a,
  input logic [VW-1:0] src_b,
  input logic [SW-1:0] elem_sz,
  input logic          out_valid,
  input logic [VW-1:0] res_even,
  input logic [VW-1:0] res_odd
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R5
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_even) && $stable(res_odd))); // R6
  AST_RSV_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && elem_sz == 2'd3) |=>
      (res_even == $past(src_a) && res_odd == $past(src_b))); // R4
  AST_WIDE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && elem_sz == 2'd2) |=>
      (res_even == {$past(src_b[63:0]), $past(src_a[63:0])})); // R3
  AST_WIDE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && elem_sz == 2'd2) |=>
      (res_odd == {$past(src_b[127:64]), $past(src_a[127:64])})); // R3
  AST_HALF_PAIR0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && elem_sz == 2'd0) |=>
      (res_even[31:0] == {$past(src_b[15:0]), $past(src_a[15:0])})); // R1
  AST_WORD_PAIR0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && elem_sz == 2'd1) |=>
      (res_odd[63:0] == {$past(src_b[63:32]), $past(src_a[63:32])})); // R2
endmodule

bind vtrn_pair_unit vtrn_pair_unit_chk #(.VW(VW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .src_a     (src_a),
  .src_b     (src_b),
  .elem_sz   (elem_sz),
  .out_valid (out_valid),
  .res_even  (res_even),
  .res_odd   (res_odd)
);

// File: tb/sim_vtrn_pair_unit.sv
`timescale 1ns/1ps
module sim_vtrn_pair_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic [1:0]   elem_sz = 2'd0;
  logic         out_valid;
  logic [127:0] res_even, res_odd;

  int nvec = 0;
  int nfail = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;
  int cyc = 0;

  always #5 clk = ~clk;

  vtrn_pair_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .elem_sz(elem_sz),
    .out_valid(out_valid), .res_even(res_even), .res_odd(res_odd)
  );

  function automatic logic [127:0] ref_trn(input logic [127:0] a, input logic [127:0] b,
                                           input logic [1:0] sz, input bit odd);
    logic [127:0] r;
    int ew, lanes, src;
    if (sz == 2'd3) return odd ? b : a;
    ew = 16 << sz;
    lanes = 128 / ew;
    r = '0;
    for (int ln = 0; ln < lanes; ln++) begin
      src = (ln / 2) * 2 + (odd ? 1 : 0);
      for (int t = 0; t < ew; t++)
        r[ln*ew + t] = (ln % 2 == 1) ? b[src*ew + t] : a[src*ew + t];
    end
    return r;
  endfunction

  // Behavioural reference model
  logic         exp_valid;
  logic [127:0] exp_even, exp_odd;
  logic [1:0]   exp_sz;
  bit           exp_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid <= 1'b0; exp_even <= '0; exp_odd <= '0;
      exp_sz <= 2'd0; exp_hold <= 1'b1;
    end else begin
      exp_valid <= in_valid;
      if (in_valid) begin
        exp_even <= ref_trn(src_a, src_b, elem_sz, 1'b0);
        exp_odd  <= ref_trn(src_a, src_b, elem_sz, 1'b1);
        exp_sz   <= elem_sz;
        exp_hold <= 1'b0;
      end else begin
        exp_hold <= 1'b1;
      end
    end
  end

  function automatic string tag_of(input logic [1:0] sz, input bit hold);
    if (hold) return "R6";
    case (sz)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  always @(negedge clk) begin
    if (chk_en && !done) begin
      nvec++;
      if (out_valid !== exp_valid) begin
        nfail++;
        $display("FAIL R5 out_valid actual=%b expected=%b", out_valid, exp_valid);
      end
      if (res_even !== exp_even || res_odd !== exp_odd) begin
        nfail++;
        $display("FAIL %s even actual=%h expected=%h odd actual=%h expected=%h",
                 tag_of(exp_sz, exp_hold), res_even, exp_even, res_odd, exp_odd);
      end
    end
  end

  task automatic send(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                      output logic [127:0] e, output logic [127:0] o);
    @(negedge clk);
    in_valid = 1'b1; src_a = a; src_b = b; elem_sz = sz;
    @(negedge clk);
    in_valid = 1'b0;
    e = res_even; o = res_odd;
  endtask

  function automatic logic [127:0] rand_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check_tile(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s tile element actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nfail++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [127:0] e, o;
    logic [127:0] r[8];
    logic [127:0] s[8];
    logic [127:0] u[4];
    logic [127:0] v[4];
    logic [127:0] q[8];

    // R7: reset state
    repeat (3) @(negedge clk);
    nvec++;
    if (out_valid !== 1'b0 || res_even !== '0 || res_odd !== '0) begin
      nfail++;
      $display("FAIL R7 reset actual=%b/%h/%h expected=0/0/0", out_valid, res_even, res_odd);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1'b1;

    // R1..R4 with random and edge patterns, gaps for R6, back-to-back for R5
    for (int sz = 0; sz < 4; sz++) begin
      send({128{1'b1}}, '0, 2'(sz), e, o);
      send('0, {128{1'b1}}, 2'(sz), e, o);
      for (int n = 0; n < 20; n++) begin
        send(rand_vec(), rand_vec(), 2'(sz), e, o);
        if (n % 4 == 0) begin
          src_a = rand_vec(); src_b = rand_vec();
          repeat (2) @(negedge clk);
        end
      end
    end
    // R5: back-to-back with mixed sizes
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      in_valid = 1'b1; src_a = rand_vec(); src_b = rand_vec(); elem_sz = 2'($urandom % 4);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);

    // R8: two-round 4x4 transpose (two tiles per vector)
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        r[i][j*16 +: 16] = 16'((i << 8) | j | 16'h4000);
    send(r[0], r[2], 2'd1, s[0], s[2]);
    send(r[1], r[3], 2'd1, s[1], s[3]);
    send(s[0], s[1], 2'd0, q[0], q[1]);
    send(s[2], s[3], 2'd0, q[2], q[3]);
    for (int blk = 0; blk < 2; blk++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          check_tile("R8", q[j][(blk*4+i)*16 +: 16], r[i][(blk*4+j)*16 +: 16]);

    // R9: three-round 8x8 transpose
    send(r[0], r[1], 2'd0, s[0], s[1]);
    send(r[2], r[3], 2'd0, s[2], s[3]);
    send(r[4], r[5], 2'd0, s[4], s[5]);
    send(r[6], r[7], 2'd0, s[6], s[7]);
    send(s[0], s[2], 2'd1, u[0], u[2]);
    send(s[1], s[3], 2'd1, u[1], u[3]);
    send(s[4], s[6], 2'd1, v[0], v[2]);
    send(s[5], s[7], 2'd1, v[1], v[3]);
    send(u[0], v[0], 2'd2, q[0], q[4]);
    send(u[1], v[1], 2'd2, q[1], q[5]);
    send(u[2], v[2], 2'd2, q[2], q[6]);
    send(u[3], v[3], 2'd2, q[3], q[7]);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        check_tile("R9", q[j][i*16 +: 16], r[i][j*16 +: 16]);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule